// File: doc/BRIEF.md
# Miss-Entry Snoop Ordering Unit

This block sits beside one allocated miss-tracking entry of a cache and decides what an incoming snoop does to that entry. The caller supplies the snoop's attributes and the entry's current status in the same cycle as a snoop-valid strobe. In that cycle the unit reports three things. First, whether the entry absorbs the snoop or the snoop is ordered ahead of the entry's outstanding request. Second, which queued upgrade requests must be rewritten. Third, whether a snoop-sourced copy must be queued as a target, and whether it will later be answered with data. It also reports the response-side flags to attach to the snoop.

Two pieces of state live here: a post-invalidate bit and a post-downgrade bit. They record coherence actions that are deferred until after the fill. Both update on the clock edge that ends the snoop cycle. A single-cycle issue strobe clears both bits when the entry's request is sent. Snoops whose write-need and invalidate attributes disagree, and which are not maintenance operations, raise a protocol-error output.

Top module: `snoop_order_unit`

## Requirements
- R1: A valid snoop precedes the entry when the entry is not in service, or when the snoop is express and downstream-pending is set. Such a snoop is not absorbed, queues no target and asserts no response flag. If it needs writable or is a cache-invalidate, `rewrite_all` is asserted.
- R2: A valid snoop that does not precede the entry and that needs writable or is a cache-invalidate asserts `rewrite_deferred` and not `rewrite_all`.
- R3: A non-preceding snoop is absorbed. If post-invalidate is already set, or the first primary target is a cache-invalidate, it has no other effect: no target, no response flags, no change to either post bit.
- R4: An absorbed snoop that is not stopped by R3 queues a target (`add_target`) when pending-modified is set or the snoop invalidates. The target's pending mark is downstream-pending AND primary-needs-writable.
- R5: `will_respond`, `set_cache_resp` and `set_had_writable` are asserted together exactly when a target is queued, pending-modified is set, the snoop needs a response and the snoop is not clean.
- R6: A queued target whose snoop needs writable or invalidates sets the post-invalidate bit at the next edge. A queued target with pending-modified and a clean snoop asserts `set_satisfied`.
- R7: An absorbed, unstopped snoop that neither needs writable nor is uncacheable asserts `set_sharers` and sets the post-downgrade bit at the next edge.
- R8: `proto_err` is asserted for a valid snoop whose needs-writable differs from its invalidate attribute, unless it is a maintenance operation. This holds regardless of ordering.
- R9: Reset clears both post bits. An `issue` strobe without a snoop in the same cycle clears both bits at the next edge. When both occur in one cycle, a snoop's set wins.
- R10: With `snp_valid` low, every per-snoop output is 0 and both post bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snp_valid | input | 1 | Snoop presented this cycle |
| snp_needs_wr | input | 1 | Snoop needs a writable copy |
| snp_inval | input | 1 | Snoop invalidates |
| snp_cache_inval | input | 1 | Snoop is a cache-invalidate operation |
| snp_maint | input | 1 | Snoop is a cache maintenance operation |
| snp_clean | input | 1 | Snoop is a clean operation |
| snp_needs_resp | input | 1 | Snoop expects a response |
| snp_express | input | 1 | Snoop is express |
| snp_uncache | input | 1 | Snoop is uncacheable |
| ent_in_service | input | 1 | Entry's request has been issued |
| ent_dn_pending | input | 1 | Entry's request is held at a downstream level |
| ent_pend_mod | input | 1 | Entry awaits a writable copy |
| prim_first_cinval | input | 1 | First primary target is a cache-invalidate |
| prim_needs_wr | input | 1 | Primary queue needs writable |
| issue | input | 1 | Entry's request sent; clears post bits |
| absorbed | output | 1 | Entry absorbs the snoop |
| rewrite_all | output | 1 | Rewrite upgrades in both queues |
| rewrite_deferred | output | 1 | Rewrite upgrades in deferred queue only |
| add_target | output | 1 | Queue snoop copy as primary target |
| add_pending | output | 1 | Pending mark of queued copy |
| will_respond | output | 1 | Entry will answer the snoop with data |
| set_cache_resp | output | 1 | Mark snoop as cache-responding |
| set_had_writable | output | 1 | Mark responder had writable |
| set_sharers | output | 1 | Mark snoop as having sharers |
| set_satisfied | output | 1 | Mark snoop as satisfied |
| proto_err | output | 1 | Inconsistent snoop attributes |
| post_inval | output | 1 | Post-invalidate bit |
| post_dgr | output | 1 | Post-downgrade bit |

## Verification
On every cycle the assertions check several invariants. A snoop to an entry that is not in service is never absorbed. The two rewrite outputs never coincide. The three response flags move together and imply a queued target. A stopped snoop queues nothing. Queued invalidating copies and sharer marks leave the matching post bit set at the next edge, and an idle cycle produces no per-snoop output. The exact decision for each attribute combination can only be shown by the bench's scenarios: precedence through the express path, the target's pending mark, satisfied versus respond, and the uncacheable exemption from downgrade. The same holds for the history-dependent stop caused by an earlier invalidating snoop, and for the clearing effect of the issue strobe.

// File: rtl/snoop_order_unit.sv
module snoop_order_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic snp_valid,
  input  logic snp_needs_wr,
  input  logic snp_inval,
  input  logic snp_cache_inval,
  input  logic snp_maint,
  input  logic snp_clean,
  input  logic snp_needs_resp,
  input  logic snp_express,
  input  logic snp_uncache,
  input  logic ent_in_service,
  input  logic ent_dn_pending,
  input  logic ent_pend_mod,
  input  logic prim_first_cinval,
  input  logic prim_needs_wr,
  input  logic issue,
  output logic absorbed,
  output logic rewrite_all,
  output logic rewrite_deferred,
  output logic add_target,
  output logic add_pending,
  output logic will_respond,
  output logic set_cache_resp,
  output logic set_had_writable,
  output logic set_sharers,
  output logic set_satisfied,
  output logic proto_err,
  output logic post_inval,
  output logic post_dgr
);

  logic ahead, wr_or_cinv, stopped, active, copy, kill_copy;

  assign ahead      = !ent_in_service || (snp_express && ent_dn_pending);
  assign wr_or_cinv = snp_needs_wr || snp_cache_inval;
  assign stopped    = post_inval || prim_first_cinval;
  assign active     = snp_valid && !ahead && !stopped;
  assign copy       = active && (ent_pend_mod || snp_inval);
  assign kill_copy  = copy && (snp_needs_wr || snp_inval);

  assign absorbed         = snp_valid && !ahead;
  assign rewrite_all      = snp_valid && ahead && wr_or_cinv;
  assign rewrite_deferred = snp_valid && !ahead && wr_or_cinv;
  assign add_target       = copy;
  assign add_pending      = copy && ent_dn_pending && prim_needs_wr;
  assign will_respond     = copy && ent_pend_mod && snp_needs_resp && !snp_clean;
  assign set_cache_resp   = will_respond;
  assign set_had_writable = will_respond;
  assign set_satisfied    = copy && ent_pend_mod && snp_clean;
  assign set_sharers      = active && !snp_needs_wr && !snp_uncache;
  assign proto_err        = snp_valid && (snp_needs_wr != snp_inval) && !snp_maint;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_inval <= 1'b0;
      post_dgr   <= 1'b0;
    end else begin
      if (kill_copy)   post_inval <= 1'b1;
      else if (issue)  post_inval <= 1'b0;
      if (set_sharers) post_dgr   <= 1'b1;
      else if (issue)  post_dgr   <= 1'b0;
    end
  end

endmodule

// File: rtl/snoop_order_chk.sv
module snoop_order_chk (
  input logic clk,
  input logic rst_n,
  input logic snp_valid,
  input logic snp_needs_wr,
  input logic snp_inval,
  input logic ent_in_service,
  input logic issue,
  input logic absorbed,
  input logic rewrite_all,
  input logic rewrite_deferred,
  input logic add_target,
  input logic will_respond,
  input logic set_cache_resp,
  input logic set_had_writable,
  input logic set_sharers,
  input logic set_satisfied,
  input logic post_inval,
  input logic post_dgr
);

  p_not_in_service_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !ent_in_service) |-> !absorbed);

  p_rewrite_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rewrite_all && rewrite_deferred));

  p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (absorbed && post_inval) |-> (!add_target && !set_sharers && !set_satisfied));

  p_resp_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (will_respond || set_cache_resp || set_had_writable) |->
      (will_respond && set_cache_resp && set_had_writable && add_target));

  p_post_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (add_target && (snp_needs_wr || snp_inval)) |=> post_inval);

  p_post_dgr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_sharers |=> post_dgr);

  p_issue_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !snp_valid) |=> (!post_inval && !post_dgr));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> (!absorbed && !rewrite_all && !rewrite_deferred &&
                    !add_target && !set_sharers && !will_respond));

endmodule

bind snoop_order_unit snoop_order_chk u_chk (.*);

// File: tb/test_snoop_order_unit.sv
module test_snoop_order_unit;
  localparam int P = 10;
  localparam int NV = 12;
  // in : nw inv cinv maint clean nresp expr unc insvc dnp pmod pfcinv pnw
  // exp: abs rall rdef add addp resp sat shr err pinv pdgr
  localparam logic [12:0] VIN [NV] = '{
    13'b1_1_0_0_0_0_0_0_0_0_0_0_0,
    13'b0_0_0_0_0_0_1_0_1_1_0_0_0,
    13'b0_0_0_0_0_1_0_0_1_1_1_0_1,
    13'b1_1_0_0_0_1_0_0_1_0_0_0_0,
    13'b0_0_0_0_1_1_0_0_1_0_1_0_0,
    13'b1_1_0_0_0_1_0_0_1_0_1_1_0,
    13'b1_0_0_0_0_0_0_0_0_0_0_0_0,
    13'b1_0_0_1_0_0_0_0_0_0_0_0_0,
    13'b0_0_0_0_0_1_0_1_1_0_0_0_0,
    13'b0_0_0_0_0_1_0_0_1_0_0_0_0,
    13'b0_0_1_1_0_0_0_0_1_0_0_0_0,
    13'b1_1_0_0_0_1_0_0_1_1_1_0_1
  };
  localparam logic [10:0] VEXP [NV] = '{
    11'b0_1_0_0_0_0_0_0_0_0_0,
    11'b0_0_0_0_0_0_0_0_0_0_0,
    11'b1_0_0_1_1_1_0_1_0_0_1,
    11'b1_0_1_1_0_0_0_0_0_1_0,
    11'b1_0_0_1_0_0_1_1_0_0_1,
    11'b1_0_1_0_0_0_0_0_0_0_0,
    11'b0_1_0_0_0_0_0_0_1_0_0,
    11'b0_1_0_0_0_0_0_0_0_0_0,
    11'b1_0_0_0_0_0_0_0_0_0_0,
    11'b1_0_0_0_0_0_0_1_0_0_1,
    11'b1_0_1_0_0_0_0_1_0_0_1,
    11'b1_0_1_1_1_1_0_0_0_1_0
  };

  logic clk = 0, rst_n = 0;
  logic snp_valid = 0, issue = 0;
  logic [12:0] vin = '0;
  logic absorbed, rewrite_all, rewrite_deferred, add_target, add_pending;
  logic will_respond, set_cache_resp, set_had_writable, set_sharers, set_satisfied;
  logic proto_err, post_inval, post_dgr;
  int n_chk = 0, n_fail = 0;

  always #(P/2) clk = ~clk;

  snoop_order_unit i_snoop_order_unit (
    .clk, .rst_n, .snp_valid,
    .snp_needs_wr(vin[12]), .snp_inval(vin[11]), .snp_cache_inval(vin[10]),
    .snp_maint(vin[9]), .snp_clean(vin[8]), .snp_needs_resp(vin[7]),
    .snp_express(vin[6]), .snp_uncache(vin[5]), .ent_in_service(vin[4]),
    .ent_dn_pending(vin[3]), .ent_pend_mod(vin[2]), .prim_first_cinval(vin[1]),
    .prim_needs_wr(vin[0]), .issue,
    .absorbed, .rewrite_all, .rewrite_deferred, .add_target, .add_pending,
    .will_respond, .set_cache_resp, .set_had_writable, .set_sharers,
    .set_satisfied, .proto_err, .post_inval, .post_dgr);

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_post();
    @(negedge clk); issue = 1; snp_valid = 0;
    @(negedge clk); issue = 0;
  endtask

  task automatic comb_check(logic [10:0] e);
    chk("R1", "absorbed", absorbed, e[10]);
    chk("R1", "rewrite_all", rewrite_all, e[9]);
    chk("R2", "rewrite_deferred", rewrite_deferred, e[8]);
    chk("R4", "add_target", add_target, e[7]);
    chk("R4", "add_pending", add_pending, e[6]);
    chk("R5", "will_respond", will_respond, e[5]);
    chk("R5", "set_cache_resp", set_cache_resp, e[5]);
    chk("R5", "set_had_writable", set_had_writable, e[5]);
    chk("R6", "set_satisfied", set_satisfied, e[4]);
    chk("R7", "set_sharers", set_sharers, e[3]);
    chk("R8", "proto_err", proto_err, e[2]);
  endtask

  initial begin
    #(P*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(P*2);
    @(negedge clk);
    chk("R9", "reset post_inval", post_inval, 1'b0);
    chk("R9", "reset post_dgr", post_dgr, 1'b0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      clear_post();
      vin = VIN[i]; snp_valid = 1;
      #(P/4);
      comb_check(VEXP[i]);
      @(negedge clk); snp_valid = 0;
      chk("R6", "post_inval", post_inval, VEXP[i][1]);
      chk("R7", "post_dgr", post_dgr, VEXP[i][0]);
    end

    // R3: an earlier invalidating snoop stops a later one
    clear_post();
    vin = 13'b1_1_0_0_0_1_0_0_1_0_0_0_0; snp_valid = 1;
    @(negedge clk);
    vin = 13'b0_0_0_0_0_1_0_0_1_0_1_0_0;
    #(P/4);
    chk("R3", "stopped absorbed", absorbed, 1'b1);
    chk("R3", "stopped add_target", add_target, 1'b0);
    chk("R3", "stopped will_respond", will_respond, 1'b0);
    chk("R3", "stopped set_sharers", set_sharers, 1'b0);
    @(negedge clk); snp_valid = 0;
    chk("R3", "stopped post_dgr", post_dgr, 1'b0);
    chk("R3", "stopped post_inval held", post_inval, 1'b1);

    // R10: idle cycle with attributes set leaves everything alone
    vin = 13'b1_0_1_0_0_1_1_0_1_0_1_0_1;
    #(P/4);
    chk("R10", "idle absorbed", absorbed, 1'b0);
    chk("R10", "idle rewrite_deferred", rewrite_deferred, 1'b0);
    chk("R10", "idle proto_err", proto_err, 1'b0);
    @(negedge clk);
    chk("R10", "idle post_inval held", post_inval, 1'b1);

    // R9: issue strobe clears; snoop set beats a concurrent issue
    @(negedge clk); issue = 1;
    @(negedge clk); issue = 0;
    chk("R9", "issue clears post_inval", post_inval, 1'b0);
    vin = 13'b0_0_0_0_0_1_0_0_1_0_0_0_0; snp_valid = 1; issue = 1;
    @(negedge clk); snp_valid = 0; issue = 0;
    chk("R9", "snoop wins over issue", post_dgr, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule